// File: doc/BRIEF.md
# Key-Guarded Flash Write-Permission Register Block

This block sits on a simple word-wide register bus and decides whether an external flash region may be written. A control word holds the flash write-enable bit and some free scratch bits. A separate guard register protects the write-enable bit. Software first writes an exact key word to the guard register. It then performs a read-modify-write of the control word, reads the word back to confirm the change, and finally writes zero to the guard register to close it again. The same sequence sets the bit and clears it.

A third register, the system-control word, drives the programming-voltage enable and the flash write-permit levels. Both levels are high while that word holds any nonzero value and low while it holds zero. Every access completes in the cycle it is presented, with no wait states. Read data is combinational from the address. A write takes effect at the clock edge that samples it.

Top module: `flashguard_top`

## Requirements
- R1: After reset the guard is closed (guard read returns 0), the control word and system-control word are 0, and flash_we, vpp_en and wr_permit are all low.
- R2: A write to the guard register (word offset 1) whose data equals the full key word 0x0000A05F opens the guard; from the next cycle the guard reads back 1.
- R3: A write to the guard register with any other value closes the guard. This covers zero and the key with any extra upper bit set. From the next cycle the guard reads back 0.
- R4: While the guard is closed, a write to the control word (offset 0) leaves bit 0 (write-enable) unchanged, while bits above bit 0 take the written value.
- R5: While the guard is open, a write to the control word updates all bits including bit 0. flash_we equals control bit 0 from the cycle after the write.
- R6: A write to the system-control word (offset 2) stores the full word. vpp_en and wr_permit are both high from the next cycle if the stored word is nonzero, and both low if it is zero.
- R7: Reads return the stored control word at offset 0, the guard state zero-extended (1 = open) at offset 1, and the system-control word at offset 2, all in the same cycle as the address. Any other offset reads 0.
- R8: A write to any offset other than 0, 1 or 2 changes no register and no output.
- R9: With the write strobe low, no register and no output changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Word offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| flash_we | output | 1 | Flash write-enable level (control bit 0) |
| vpp_en | output | 1 | Programming-voltage enable level |
| wr_permit | output | 1 | Flash write-permit level |

## Verification
Every offset is written with a set of data patterns from both guard states, and all registers and outputs are compared with a model after each write. The key-with-an-upper-bit case catches a design that compares only the low half-word and would open the guard on a wrong key. The writes to the control word while the guard is closed catch two faults: a design that lets bit 0 through, which would raise flash_we, and one that also freezes the scratch bits, which would read back stale upper bits. Writes to unmapped offsets and cycles with the strobe low catch a decoder that aliases addresses or ignores the strobe, which would silently change a stored word.

// File: rtl/flashguard_pkg.sv
package flashguard_pkg;
  // Word offsets; software depends on these positions.
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_LOCK = 1;
  localparam int unsigned OFS_SYS  = 2;
  // Bit position of the write-enable flag inside the control word.
  localparam int unsigned WE_BIT   = 0;
endpackage

// File: rtl/flashguard_lock.sv
module flashguard_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic key_match;

  assign key_match = (wdata == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (wr_hit) begin
      unlocked <= key_match;
    end
  end
endmodule

// File: rtl/flashguard_ctrl.sv
module flashguard_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  import flashguard_pkg::*;

  // Per-bit write mask: the guarded bit needs the guard open, the rest do not.
  logic [DATA_W-1:0] bit_wr;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == WE_BIT) begin : g_guarded
        assign bit_wr[b] = wr_hit & unlocked;
      end else begin : g_free
        assign bit_wr[b] = wr_hit;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          ctrl_q[b] <= 1'b0;
        end else if (bit_wr[b]) begin
          ctrl_q[b] <= wdata[b];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/flashguard_sysctl.sv
module flashguard_sysctl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sys_q,
  output logic              vpp_en,
  output logic              wr_permit
);
  logic active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= '0;
    end else if (wr_hit) begin
      sys_q <= wdata;
    end
  end

  assign active    = |sys_q;
  assign vpp_en    = active;
  assign wr_permit = active;
endmodule

// File: rtl/flashguard_top.sv
module flashguard_top #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              flash_we,
  output logic              vpp_en,
  output logic              wr_permit
);
  import flashguard_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(OFS_SYS);

  logic sel_ctrl, sel_lock, sel_sys;
  logic unlocked_q;
  logic [DATA_W-1:0] ctrl_q, sys_q;

  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_lock = (bus_addr == A_LOCK);
  assign sel_sys  = (bus_addr == A_SYS);

  flashguard_lock #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (bus_wr & sel_lock),
    .wdata    (bus_wdata),
    .unlocked (unlocked_q)
  );

  flashguard_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (bus_wr & sel_ctrl),
    .unlocked (unlocked_q),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q)
  );

  flashguard_sysctl #(.DATA_W(DATA_W)) u_sys (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (bus_wr & sel_sys),
    .wdata     (bus_wdata),
    .sys_q     (sys_q),
    .vpp_en    (vpp_en),
    .wr_permit (wr_permit)
  );

  assign flash_we = ctrl_q[WE_BIT];

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata = ctrl_q;
    end else if (sel_lock) begin
      bus_rdata = DATA_W'(unlocked_q);
    end else if (sel_sys) begin
      bus_rdata = sys_q;
    end
  end
endmodule

// File: rtl/flashguard_chk.sv
module flashguard_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A05F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              unlocked,
  input logic              flash_we,
  input logic              vpp_en,
  input logic              wr_permit
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(2);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!unlocked && !flash_we && !vpp_en && !wr_permit));

  p_key_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LOCK && bus_wdata == UNLOCK_KEY) |=> unlocked);

  p_other_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LOCK && bus_wdata != UNLOCK_KEY) |=> !unlocked);

  p_closed_holds_we_r4: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && bus_wr && bus_addr == A_CTRL) |=> $stable(flash_we));

  p_we_change_needs_open_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(flash_we) |-> $past(unlocked && bus_wr && bus_addr == A_CTRL));

  p_sys_levels_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SYS) |=>
      (vpp_en == ($past(bus_wdata) != '0)) && (wr_permit == vpp_en));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ($stable(unlocked) && $stable(flash_we) && $stable(vpp_en)));
endmodule

bind flashguard_top flashguard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .unlocked  (unlocked_q),
  .flash_we  (flash_we),
  .vpp_en    (vpp_en),
  .wr_permit (wr_permit)
);

// File: tb/test_flashguard_top.sv
module test_flashguard_top;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] KEY = 32'h0000_A05F;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              flash_we, vpp_en, wr_permit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model of the three stored words.
  logic        m_open = 1'b0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_sys  = '0;

  always #2 clk = ~clk;

  flashguard_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_flashguard_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_we(flash_we),
    .vpp_en(vpp_en), .wr_permit(wr_permit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle (at negedge); the edge in between commits it.
  task automatic cycle(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    if (wr) begin
      case (a)
        ADDR_W'(0): m_ctrl = {d[31:1], m_open ? d[0] : m_ctrl[0]};
        ADDR_W'(1): m_open = (d == KEY);
        ADDR_W'(2): m_sys  = d;
        default: ;
      endcase
    end
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic check_all(input string req);
    read_chk(req, ADDR_W'(0), m_ctrl);
    read_chk(req, ADDR_W'(1), {31'd0, m_open});
    read_chk(req, ADDR_W'(2), m_sys);
    read_chk("R7", ADDR_W'(3), 32'd0);
    check(req, {29'd0, flash_we, vpp_en, wr_permit},
          {29'd0, m_ctrl[0], |m_sys, |m_sys});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001;
    pats[2] = 32'hFFFF_FFFE; pats[3] = KEY;
    pats[4] = 32'h0001_A05F; pats[5] = 32'hFFFF_FFFF;

    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // Directed sequence: open, set WE, close, try to clear, reopen, clear.
    cycle(1, ADDR_W'(1), KEY);          check_all("R2");
    cycle(1, ADDR_W'(0), 32'h0000_0005); check_all("R5");
    check("R5", {31'd0, flash_we}, 32'd1);
    cycle(1, ADDR_W'(1), 32'd0);        check_all("R3");
    cycle(1, ADDR_W'(0), 32'h0000_00F0); check_all("R4");
    check("R4", {31'd0, flash_we}, 32'd1);
    cycle(1, ADDR_W'(1), 32'h0001_A05F); check_all("R3");
    cycle(1, ADDR_W'(1), KEY);
    cycle(1, ADDR_W'(0), 32'h0000_00F0); check_all("R5");
    check("R5", {31'd0, flash_we}, 32'd0);
    cycle(1, ADDR_W'(2), 32'h0000_0100); check_all("R6");
    check("R6", {30'd0, vpp_en, wr_permit}, 32'd3);
    cycle(1, ADDR_W'(2), 32'd0);        check_all("R6");

    // Strobe low with every address and a hostile data word.
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      cycle(0, ADDR_W'(a), (a == 1) ? KEY : 32'hFFFF_FFFF);
      check_all("R9");
    end

    // Sweep: every offset, both guard states, every pattern.
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      for (int g = 0; g < 2; g++) begin
        for (int p = 0; p < 6; p++) begin
          string req;
          cycle(1, ADDR_W'(1), g ? KEY : 32'd0);
          if (a == 0)      req = g ? "R5" : "R4";
          else if (a == 1) req = (pats[p] == KEY) ? "R2" : "R3";
          else if (a == 2) req = "R6";
          else             req = "R8";
          cycle(1, ADDR_W'(a), pats[p]);
          check_all(req);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule